// File: doc/BRIEF.md
# Pulsed Byte Programming Sequencer

This block is the programmer-side sequencer that writes one byte into a pulse-programmed nonvolatile array. A single start strobe latches a target address, a data byte and a write mode. The sequencer then presents the address (split over a low and a high output field) and the data byte, turns on the high-voltage programming supply, and drives a fixed train of active-low program pulses. It then turns the supply off, holds address and data for a final margin, releases every pin and raises a done flag for one cycle.

Every interval is a parameter counted in system clock cycles: the address and data lead, the supply lead, the low width of a pulse, the high gap between pulses, the supply tail and the address and data tail. The integrator converts the microsecond and oscillator-period limits of the target array into these counts. The same pulse train serves four write modes: main code bytes, the 32-entry key table, and the two protection bits. Only the mode-select outputs and the shaping of the address and data differ between them.

Top module: `burn_seq_ctrl`

## Requirements
- R1: While `rst` is high and after it falls with no start, `prog_n_o` is 1 and `vpp_en_o`, `done_o`, `sel_o`, `addr_lo_o`, `addr_hi_o` and `data_o` are 0. A reset in the middle of an operation returns the pins to these values at the next clock edge.
- R2: Each accepted start produces exactly PULSES low periods on `prog_n_o`, and `prog_n_o` is never low while `vpp_en_o` is low.
- R3: Each low period of `prog_n_o` lasts exactly LOW_CYC cycles. Consecutive pulses are separated by exactly HIGH_CYC high cycles.
- R4: `vpp_en_o` rises exactly VPP_SU_CYC cycles before the first pulse falls. It falls exactly VPP_HOLD_CYC cycles after the last pulse rises.
- R5: Address, data and select are driven from the first cycle after the start edge, which is SETUP_CYC+VPP_SU_CYC cycles before the first pulse falls. They stay constant until VPP_HOLD_CYC+REL_CYC cycles after the last pulse rises and are 0 at every other time.
- R6: A start strobe during an operation is ignored. It changes no output value and adds no pulse.
- R7: `done_o` is high for exactly one cycle, which is the first cycle in which the pins are released.
- R8: `sel_o` is one-hot while driven: mode 0 (code) sets bit 0, mode 1 (key table) sets bit 1, mode 2 (first protection bit) sets bit 2, and mode 3 (second protection bit) sets bit 3.
- R9: In mode 1, `addr_lo_o` carries only `addr_i[4:0]`, its upper bits and `addr_hi_o` are 0, and `data_o` equals `data_i`.
- R10: In modes 2 and 3, `addr_lo_o`, `addr_hi_o` and `data_o` are all 0.
- R11: In mode 0, `addr_lo_o` = `addr_i[7:0]`, `addr_hi_o` = `addr_i[11:8]` and `data_o` = `data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| mode_i | input | 2 | Write mode (0 code, 1 key table, 2/3 protection bits) |
| addr_i | input | ADDR_W | Target address |
| data_i | input | DATA_W | Byte to write |
| addr_lo_o | output | LO_W | Low address field |
| addr_hi_o | output | ADDR_W-LO_W | High address field |
| data_o | output | DATA_W | Data field |
| sel_o | output | 4 | One-hot mode-select levels |
| vpp_en_o | output | 1 | Programming supply enable |
| prog_n_o | output | 1 | Active-low program pulse |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The bench records the cycle of every edge on the supply enable, the program line and the select field. It then checks the pulse count, every low width and every gap, and all four margins around the train. A sequencer with an off-by-one counter would give 24 or 26 pulses, or widths one cycle short. A sequencer that dropped the supply straight after the last low period would break the tail margin. Mode shaping is checked at the key-table boundary address 1Fh and with an all-ones address. A design that did not mask would leak high address bits into the key table or address bits into protection-bit writes. A start injected mid-train and a reset mid-train are also applied. Either one would show up as a changed address, extra pulses or pins left driven.

// File: rtl/burn_pkg.sv
package burn_pkg;

  typedef enum logic [1:0] {
    MODE_CODE   = 2'd0,
    MODE_KEY    = 2'd1,
    MODE_LOCK_A = 2'd2,
    MODE_LOCK_B = 2'd3
  } burn_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_VPP_ON,
    ST_PULSE_LOW,
    ST_PULSE_HIGH,
    ST_VPP_HOLD,
    ST_RELEASE,
    ST_DONE
  } burn_state_e;

  function automatic int bmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/burn_timer.sv
module burn_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R3
  timer_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/burn_tally.sv
module burn_tally #(
  parameter int PULSES = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic last
);
  localparam int CW = (PULSES > 1) ? $clog2(PULSES) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == CW'(PULSES - 1));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |-> !last);
endmodule

// File: rtl/burn_pins.sv
module burn_pins
  import burn_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int LO_W   = 8,
  parameter int KEY_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  burn_state_e            st_d,
  input  burn_mode_e             mode,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      data,
  output logic [LO_W-1:0]        addr_lo_o,
  output logic [ADDR_W-LO_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0]      data_o,
  output logic [3:0]             sel_o,
  output logic                   vpp_en_o,
  output logic                   prog_n_o,
  output logic                   done_o
);
  logic [ADDR_W-1:0] a_sh;
  logic [DATA_W-1:0] d_sh;
  logic              drive, vpp;

  always_comb begin
    unique case (mode)
      MODE_CODE: begin a_sh = addr;                           d_sh = data; end
      MODE_KEY:  begin a_sh = ADDR_W'(addr[KEY_W-1:0]);       d_sh = data; end
      default:   begin a_sh = '0;                             d_sh = '0;   end
    endcase
  end

  assign drive = st_d inside {ST_SETUP, ST_VPP_ON, ST_PULSE_LOW,
                              ST_PULSE_HIGH, ST_VPP_HOLD, ST_RELEASE};
  assign vpp   = st_d inside {ST_VPP_ON, ST_PULSE_LOW, ST_PULSE_HIGH, ST_VPP_HOLD};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_lo_o <= '0;
      addr_hi_o <= '0;
      data_o    <= '0;
      sel_o     <= '0;
      vpp_en_o  <= 1'b0;
      prog_n_o  <= 1'b1;
      done_o    <= 1'b0;
    end else begin
      addr_lo_o <= drive ? a_sh[LO_W-1:0]      : '0;
      addr_hi_o <= drive ? a_sh[ADDR_W-1:LO_W] : '0;
      data_o    <= drive ? d_sh                : '0;
      sel_o     <= drive ? (4'd1 << mode)      : 4'd0;
      vpp_en_o  <= vpp;
      prog_n_o  <= (st_d != ST_PULSE_LOW);
      done_o    <= (st_d == ST_DONE);
    end
  end

  // R2
  pulse_in_supply_chk: assert property (@(posedge clk) disable iff (rst)
    !prog_n_o |-> vpp_en_o);
  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o));
  // R5
  supply_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    vpp_en_o |-> sel_o != 4'd0);
  // R5
  fields_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_o != 4'd0 && $past(sel_o) != 4'd0) |->
      ($stable(addr_lo_o) && $stable(addr_hi_o) && $stable(data_o) && $stable(sel_o)));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R7
  done_released_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (sel_o == 4'd0 && !vpp_en_o));
endmodule

// File: rtl/burn_seq_ctrl.sv
module burn_seq_ctrl
  import burn_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int LO_W         = 8,
  parameter int KEY_W        = 5,
  parameter int PULSES       = 25,
  parameter int SETUP_CYC    = 600,
  parameter int VPP_SU_CYC   = 600,
  parameter int LOW_CYC      = 5000,
  parameter int HIGH_CYC     = 600,
  parameter int VPP_HOLD_CYC = 600,
  parameter int REL_CYC      = 600
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [1:0]             mode_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      data_i,
  output logic [LO_W-1:0]        addr_lo_o,
  output logic [ADDR_W-LO_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0]      data_o,
  output logic [3:0]             sel_o,
  output logic                   vpp_en_o,
  output logic                   prog_n_o,
  output logic                   done_o
);
  localparam int MAX_CYC = bmax(bmax(bmax(SETUP_CYC, VPP_SU_CYC), bmax(LOW_CYC, HIGH_CYC)),
                                bmax(VPP_HOLD_CYC, REL_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  burn_state_e       st_q, st_d;
  logic              tmr_load, tmr_zero, tally_clr, tally_step, tally_last, accept;
  logic [CNT_W-1:0]  tmr_val;
  burn_mode_e        op_mode_q, op_mode_d;
  logic [ADDR_W-1:0] op_addr_q, op_addr_d;
  logic [DATA_W-1:0] op_data_q, op_data_d;

  assign accept = (st_q == ST_IDLE) && start_i;

  always_comb begin
    st_d       = st_q;
    tally_clr  = 1'b0;
    tally_step = 1'b0;
    unique case (st_q)
      ST_IDLE:       if (start_i) begin st_d = ST_SETUP; tally_clr = 1'b1; end
      ST_SETUP:      if (tmr_zero) st_d = ST_VPP_ON;
      ST_VPP_ON:     if (tmr_zero) st_d = ST_PULSE_LOW;
      ST_PULSE_LOW:  if (tmr_zero) st_d = tally_last ? ST_VPP_HOLD : ST_PULSE_HIGH;
      ST_PULSE_HIGH: if (tmr_zero) begin st_d = ST_PULSE_LOW; tally_step = 1'b1; end
      ST_VPP_HOLD:   if (tmr_zero) st_d = ST_RELEASE;
      ST_RELEASE:    if (tmr_zero) st_d = ST_DONE;
      ST_DONE:       st_d = ST_IDLE;
    endcase
    tmr_load = (st_d != st_q);
    unique case (st_d)
      ST_SETUP:      tmr_val = CNT_W'(SETUP_CYC - 1);
      ST_VPP_ON:     tmr_val = CNT_W'(VPP_SU_CYC - 1);
      ST_PULSE_LOW:  tmr_val = CNT_W'(LOW_CYC - 1);
      ST_PULSE_HIGH: tmr_val = CNT_W'(HIGH_CYC - 1);
      ST_VPP_HOLD:   tmr_val = CNT_W'(VPP_HOLD_CYC - 1);
      ST_RELEASE:    tmr_val = CNT_W'(REL_CYC - 1);
      default:       tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign op_mode_d = accept ? burn_mode_e'(mode_i) : op_mode_q;
  assign op_addr_d = accept ? addr_i : op_addr_q;
  assign op_data_d = accept ? data_i : op_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_mode_q <= MODE_CODE;
      op_addr_q <= '0;
      op_data_q <= '0;
    end else begin
      op_mode_q <= op_mode_d;
      op_addr_q <= op_addr_d;
      op_data_q <= op_data_d;
    end
  end

  burn_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_zero)
  );

  burn_tally #(.PULSES(PULSES)) u_tally (
    .clk(clk), .rst(rst), .clear(tally_clr), .step(tally_step), .last(tally_last)
  );

  burn_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO_W(LO_W), .KEY_W(KEY_W)) u_pins (
    .clk(clk), .rst(rst), .st_d(st_d), .mode(op_mode_d), .addr(op_addr_d), .data(op_data_d),
    .addr_lo_o(addr_lo_o), .addr_hi_o(addr_hi_o), .data_o(data_o), .sel_o(sel_o),
    .vpp_en_o(vpp_en_o), .prog_n_o(prog_n_o), .done_o(done_o)
  );

  // R6
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |=> (op_addr_q == $past(op_addr_q) && op_data_q == $past(op_data_q)
                           && op_mode_q == $past(op_mode_q)));
  // R2
  last_pulse_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PULSE_LOW && st_d == ST_VPP_HOLD) |-> tmr_zero);
endmodule

// File: tb/burn_seq_ctrl_test.sv
`timescale 1ns/1ps
module burn_seq_ctrl_test;
  localparam int SU = 6, VS = 4, LO = 9, HI = 3, VH = 4, RL = 5, NP = 25;

  logic        clk = 1'b0, rst = 1'b1, start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [11:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [7:0]  addr_lo_o;
  logic [3:0]  addr_hi_o;
  logic [7:0]  data_o;
  logic [3:0]  sel_o;
  logic        vpp_en_o, prog_n_o, done_o;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  burn_seq_ctrl #(.ADDR_W(12), .DATA_W(8), .LO_W(8), .KEY_W(5), .PULSES(NP),
    .SETUP_CYC(SU), .VPP_SU_CYC(VS), .LOW_CYC(LO), .HIGH_CYC(HI),
    .VPP_HOLD_CYC(VH), .REL_CYC(RL)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i), .addr_i(addr_i),
    .data_i(data_i), .addr_lo_o(addr_lo_o), .addr_hi_o(addr_hi_o), .data_o(data_o),
    .sel_o(sel_o), .vpp_en_o(vpp_en_o), .prog_n_o(prog_n_o), .done_o(done_o));

  // {mode, addr, data, exp_lo, exp_hi, exp_data, exp_sel}
  localparam logic [45:0] VEC [0:5] = '{
    {2'd0, 12'hA5C, 8'h3E, 8'h5C, 4'hA, 8'h3E, 4'b0001},
    {2'd1, 12'hF37, 8'h81, 8'h17, 4'h0, 8'h81, 4'b0010},
    {2'd2, 12'h123, 8'hFF, 8'h00, 4'h0, 8'h00, 4'b0100},
    {2'd3, 12'hFFF, 8'h55, 8'h00, 4'h0, 8'h00, 4'b1000},
    {2'd0, 12'hFFF, 8'h00, 8'hFF, 4'hF, 8'h00, 4'b0001},
    {2'd1, 12'h01F, 8'hC3, 8'h1F, 4'h0, 8'hC3, 4'b0010}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit pins_idle();
    return prog_n_o && !vpp_en_o && !done_o && sel_o == 0 &&
           addr_lo_o == 0 && addr_hi_o == 0 && data_o == 0;
  endfunction

  task automatic run_op(input logic [45:0] v, input bit inject, input string vreq);
    int t_v0 = -1, t_l0 = -1, t_lr = -1, t_vf = -1, t_df = -1, t_done = -1;
    int lows = 0, lowrun = 0, highrun = 0, bad_low = 0, bad_gap = 0;
    int nov = 0, badval = 0, dones = 0;
    bit prev_prog = 1'b1, prev_vpp = 1'b0, prev_drv = 1'b0, drv;
    @(negedge clk);
    {mode_i, addr_i, data_i} = v[45:24];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t < 2000; t++) begin
      drv = (sel_o != 0);
      if (t == 0) chk("R5 drive at first cycle", int'(drv), 1);
      if (drv) begin
        if ({addr_lo_o, addr_hi_o, data_o, sel_o} != v[23:0]) badval++;
      end else if (addr_lo_o != 0 || addr_hi_o != 0 || data_o != 0) badval++;
      if (vpp_en_o && !prev_vpp && t_v0 < 0) t_v0 = t;
      if (!vpp_en_o && prev_vpp) t_vf = t;
      if (!prog_n_o) begin
        if (prev_prog) begin
          if (lows > 0 && highrun != HI) bad_gap++;
          lows++;
          if (t_l0 < 0) t_l0 = t;
        end
        lowrun++;
        if (!vpp_en_o) nov++;
      end else begin
        if (!prev_prog) begin
          if (lowrun != LO) bad_low++;
          t_lr = t; lowrun = 0; highrun = 0;
        end
        highrun++;
      end
      if (!drv && prev_drv) t_df = t;
      if (done_o) begin dones++; t_done = t; end
      if (inject && t == 40) begin
        mode_i = 2'd0; addr_i = 12'h999; data_i = 8'h66; start_i = 1'b1;
      end
      if (inject && t == 41) start_i = 1'b0;
      prev_prog = prog_n_o; prev_vpp = vpp_en_o; prev_drv = drv;
      if (t_done >= 0 && t > t_done) break;
      @(negedge clk);
    end
    chk("R2 pulse count", lows, NP);
    chk("R2 low without supply", nov, 0);
    chk("R3 bad low widths", bad_low, 0);
    chk("R3 bad gaps", bad_gap, 0);
    chk("R4 supply lead", t_l0 - t_v0, VS);
    chk("R4 supply tail", t_vf - t_lr, VH);
    chk("R5 field lead", t_l0, SU + VS);
    chk("R5 field tail", t_df - t_lr, VH + RL);
    chk(vreq, badval, 0);
    chk("R7 done count", dones, 1);
    chk("R7 done cycle", t_done, t_df);
    if (inject) chk("R6 pulses with mid-op start", lows, NP);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pins in reset", int'(pins_idle()), 1);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 pins idle after reset", int'(pins_idle()), 1);

    for (int i = 0; i < 6; i++) begin
      string vreq;
      case (VEC[i][45:44])
        2'd0:    vreq = "R8/R11 fields";
        2'd1:    vreq = "R8/R9 fields";
        default: vreq = "R8/R10 fields";
      endcase
      run_op(VEC[i], i == 2, vreq);
    end

    // mid-operation reset
    @(negedge clk);
    {mode_i, addr_i, data_i} = {2'd0, 12'h7E1, 8'hA9};
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (30) @(negedge clk);
    chk("R1 op running before reset", int'(sel_o), 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 pins after mid-op reset", int'(pins_idle()), 1);
    rst = 1'b0;
    begin
      int active = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (!pins_idle()) active++;
      end
      chk("R1 no activity after reset", active, 0);
    end

    run_op(VEC[0], 1'b0, "R11 fields after reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule